// File: doc/BRIEF.md
# Debug Run-Mode Controller with Instruction Jam

This block is the run-control state machine that sits between an external debug probe and a processor core. The probe selects one of four modes over a 2-bit request that is asynchronous to the core clock: free running, halted, single-step, or a jam mode. In jam mode normal fetch is suppressed and the word on the instruction bus is captured into the decode latch. The probe can therefore push its own instructions into the core, for example to save or restore state.

The request is brought into the core clock domain and filtered, so only a value that has settled is acted on. Each newly accepted request drives one mode transition. The block produces the fetch enable, the advance control, and a one-cycle decode-latch load strobe together with the captured word. It also reports the current mode so the probe can confirm every step. To run a jammed instruction, the probe moves from jam mode to single-step. The core executes that one word and the controller drops back to halt, ready for the next jam. Feeding instructions this way is much slower than free running.

Top module: `dbg_runctl`

## Requirements
- R1: After reset the status reads halt (01), fetch_en, advance and dlatch_load are low, and jam_word is zero.
- R2: mode_stat encodes the current mode as RUN=00, HALT=01, SINGLE-STEP=10, JAM=11, and the request input uses the same encoding.
- R3: A request change that is held steady is acted on at the fifth rising clock edge after it is applied. The mode does not change at any of the first four edges.
- R4: A request value that is present for only one clock cycle is ignored. Mode, fetch_en, advance and dlatch_load are unaffected.
- R5: fetch_en is high exactly while the mode is RUN. advance is high throughout RUN.
- R6: A request to leave RUN takes effect only at a cycle where insn_boundary is high. Until then the mode stays RUN and fetch_en stays high.
- R7: A SINGLE-STEP request gives exactly one cycle with advance high and fetch_en low, then returns to HALT by itself. Another step needs the request to change away and back.
- R8: On entry to JAM, dlatch_load pulses for one cycle and jam_word takes the instruction bus value. While JAM is held there are no further loads, and jam_word holds its value even when the bus changes.
- R9: If a RUN request is accepted while a leave-RUN request is still waiting for a boundary, the waiting request is cancelled. A later boundary then leaves the mode at RUN.
- R10: If a leave-RUN request is accepted in the same cycle that insn_boundary is high, the transition happens at that edge.
- R11: Repeating the request that was last accepted causes no transition, no advance pulse and no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_a | input | 2 | Mode request from the debug probe, asynchronous |
| insn_boundary | input | 1 | High when the core is at an instruction boundary |
| ibus_word | input | W | Word on the instruction bus |
| fetch_en | output | 1 | Enables normal instruction fetch |
| advance | output | 1 | Lets the pipeline advance |
| dlatch_load | output | 1 | One-cycle strobe loading the jammed word into decode |
| jam_word | output | W | Word captured on entry to jam mode |
| mode_stat | output | 2 | Current mode |

## Verification
Two functions can fall in the same cycle: a newly accepted request and the core's instruction-boundary flag. The bench raises insn_boundary for exactly the one cycle in which the filtered request is first presented to the state machine. It expects the mode to leave RUN at that edge and not wait for a later boundary. In the contrasting case, a request is left pending across several cycles with the boundary low and is then cancelled by a RUN request. There the bench expects a later boundary to keep the core running with fetch enabled.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'b00,
    M_HALT = 2'b01,
    M_STEP = 2'b10,
    M_JAM  = 2'b11
  } mode_e;
endpackage

// File: rtl/rc_rstsync.sv
module rc_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic r0_q, r1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= 1'b0;
      r1_q <= 1'b0;
    end else begin
      r0_q <= 1'b1;
      r1_q <= r0_q;
    end
  end

  assign rst_ni = r1_q;
endmodule

// File: rtl/rc_reqsync.sv
module rc_reqsync
  import rc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] req_a,
  output logic [1:0] acc_o,
  output logic       strobe_o
);
  localparam int LIM = STABLE_CYCLES - 1;
  localparam int CW  = $clog2(STABLE_CYCLES + 1);

  logic [1:0]    stg_q [SYNC_STAGES];
  logic [1:0]    smp;
  logic [1:0]    prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    acc_q, acc_d;
  logic          stb_q, stb_d;
  logic          accept;

  // synchronizer chain
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= M_HALT;
    else         stg_q[0] <= req_a;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= M_HALT;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  endgenerate

  assign smp = stg_q[SYNC_STAGES-1];

  // stability filter, next state
  always_comb begin
    cnt_d = cnt_q;
    if (smp != prev_q)              cnt_d = '0;
    else if (int'(cnt_q) != LIM)    cnt_d = cnt_q + 1'b1;
    accept = (smp == prev_q) && (int'(cnt_q) + 1 >= LIM) && (smp != acc_q);
    acc_d  = accept ? smp : acc_q;
    stb_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= M_HALT;
      cnt_q  <= '0;
      acc_q  <= M_HALT;
      stb_q  <= 1'b0;
    end else begin
      prev_q <= smp;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      stb_q  <= stb_d;
    end
  end

  assign acc_o    = acc_q;
  assign strobe_o = stb_q;

  AST_STROBE_SETTLED: assert property (@(posedge clk) disable iff (!rst_ni)
    strobe_o |-> (acc_o == $past(smp)) && ($past(smp) == $past(prev_q))); // R4
  AST_ACC_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    !strobe_o |-> $stable(acc_o)); // R11
endmodule

// File: rtl/rc_fsm.sv
module rc_fsm
  import rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] tgt_i,
  input  logic       bnd_i,
  output mode_e      mode_o,
  output logic       enter_jam_o
);
  mode_e st_q, st_d;
  logic  pend_q, pend_d;
  mode_e ptgt_q, ptgt_d;
  mode_e tgt;

  assign tgt = mode_e'(tgt_i);

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    ptgt_d = ptgt_q;
    unique case (st_q)
      M_RUN: begin
        if (strobe_i) begin
          if (tgt == M_RUN) begin
            pend_d = 1'b0;
          end else if (bnd_i) begin
            st_d   = tgt;
            pend_d = 1'b0;
          end else begin
            pend_d = 1'b1;
            ptgt_d = tgt;
          end
        end else if (pend_q && bnd_i) begin
          st_d   = ptgt_q;
          pend_d = 1'b0;
        end
      end
      M_STEP: begin
        st_d = strobe_i ? tgt : M_HALT;
      end
      default: begin
        if (strobe_i) st_d = tgt;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_HALT;
      pend_q <= 1'b0;
      ptgt_q <= M_HALT;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      ptgt_q <= ptgt_d;
    end
  end

  assign mode_o      = st_q;
  assign enter_jam_o = (st_d == M_JAM) && (st_q != M_JAM);

  AST_LEAVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == M_RUN) && !bnd_i |=> (st_q == M_RUN)); // R6
  AST_STEP_RETURNS: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == M_STEP) && !strobe_i |=> (st_q == M_HALT)); // R7
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import rc_pkg::*;
#(
  parameter int W             = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_req_a,
  input  logic         insn_boundary,
  input  logic [W-1:0] ibus_word,
  output logic         fetch_en,
  output logic         advance,
  output logic         dlatch_load,
  output logic [W-1:0] jam_word,
  output logic [1:0]   mode_stat
);
  logic         rst_ni;
  logic [1:0]   acc;
  logic         strobe;
  mode_e        mode;
  logic         enter_jam;
  logic         load_q;
  logic [W-1:0] jam_q;

  rc_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  rc_reqsync #(
    .SYNC_STAGES   (SYNC_STAGES),
    .STABLE_CYCLES (STABLE_CYCLES)
  ) u_req (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .req_a    (mode_req_a),
    .acc_o    (acc),
    .strobe_o (strobe)
  );

  rc_fsm u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .tgt_i       (acc),
    .bnd_i       (insn_boundary),
    .mode_o      (mode),
    .enter_jam_o (enter_jam)
  );

  // jam capture, clock-enabled by jam entry
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      jam_q  <= '0;
    end else begin
      load_q <= enter_jam;
      if (enter_jam) jam_q <= ibus_word;
    end
  end

  assign fetch_en    = (mode == M_RUN);
  assign advance     = (mode == M_RUN) || (mode == M_STEP);
  assign dlatch_load = load_q;
  assign jam_word    = jam_q;
  assign mode_stat   = mode;

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    dlatch_load |=> !dlatch_load); // R8
  AST_LOAD_IN_JAM: assert property (@(posedge clk) disable iff (!rst_ni)
    dlatch_load |-> (mode_stat == 2'b11) && !fetch_en); // R8
  AST_JAM_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(jam_word) |-> dlatch_load); // R8
  AST_STEP_ONE_ADV: assert property (@(posedge clk) disable iff (!rst_ni)
    advance && !fetch_en |=> !(advance && !fetch_en) || $past(strobe)); // R7
  AST_FETCH_LEAVES_AT_BND: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(fetch_en) |-> $past(insn_boundary)); // R6
endmodule

// File: tb/dbg_runctl_bench.sv
module dbg_runctl_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode_req_a;
  logic         insn_boundary;
  logic [W-1:0] ibus_word;
  logic         fetch_en, advance, dlatch_load;
  logic [W-1:0] jam_word;
  logic [1:0]   mode_stat;

  int checks = 0;
  int errors = 0;
  int step_cnt = 0;
  int load_cnt = 0;
  logic [1:0] last_req;
  logic [1:0] cur;

  always #2.5 clk = ~clk;

  dbg_runctl #(.W(W)) u_dbg_runctl (
    .clk (clk), .rst_n (rst_n), .mode_req_a (mode_req_a),
    .insn_boundary (insn_boundary), .ibus_word (ibus_word),
    .fetch_en (fetch_en), .advance (advance), .dlatch_load (dlatch_load),
    .jam_word (jam_word), .mode_stat (mode_stat)
  );

  // pulse monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (advance && !fetch_en) step_cnt++;
    if (dlatch_load) load_cnt++;
  end

  function automatic logic [1:0] exp_after(input logic [1:0] t);
    return (t == 2'b10) ? 2'b01 : t;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst_n = 1'b0; mode_req_a = 2'b01; insn_boundary = 1'b0; ibus_word = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1 mode", mode_stat, 2'b01);
    chk("R1 fetch", fetch_en, 0);
    chk("R1 advance", advance, 0);
    chk("R1 load", dlatch_load, 0);
    chk("R1 jam", jam_word, 0);

    // R3 exact latency: HALT -> RUN
    mode_req_a = 2'b00;
    cyc(4);
    chk("R3 not before fifth edge", mode_stat, 2'b01);
    cyc(1);
    chk("R3 at fifth edge", mode_stat, 2'b00);
    chk("R5 fetch in RUN", fetch_en, 1);
    chk("R5 advance in RUN", advance, 1);

    // R6 leave RUN waits for boundary
    mode_req_a = 2'b01;
    cyc(10);
    chk("R6 still RUN", mode_stat, 2'b00);
    chk("R6 fetch held", fetch_en, 1);
    // R9 cancel with RUN request
    mode_req_a = 2'b00;
    cyc(10);
    insn_boundary = 1'b1; cyc(1); insn_boundary = 1'b0;
    cyc(3);
    chk("R9 cancelled stays RUN", mode_stat, 2'b00);
    chk("R9 fetch on", fetch_en, 1);

    // R10 request and boundary in the same cycle
    mode_req_a = 2'b01;
    cyc(4);
    chk("R10 RUN before strobe", mode_stat, 2'b00);
    insn_boundary = 1'b1;
    cyc(1);
    insn_boundary = 1'b0;
    chk("R10 HALT at coincident boundary", mode_stat, 2'b01);
    chk("R5 fetch off in HALT", fetch_en, 0);

    // R4 one-cycle glitch ignored
    step_cnt = 0; load_cnt = 0;
    mode_req_a = 2'b11; cyc(1); mode_req_a = 2'b01;
    cyc(10);
    chk("R4 glitch mode", mode_stat, 2'b01);
    chk("R4 glitch loads", load_cnt, 0);
    chk("R4 glitch steps", step_cnt, 0);

    // R8 jam entry and hold
    ibus_word = 32'hA5C3_0F1E;
    mode_req_a = 2'b11;
    cyc(10);
    chk("R2 JAM code", mode_stat, 2'b11);
    chk("R8 one load", load_cnt, 1);
    chk("R8 jam word", jam_word, 32'hA5C3_0F1E);
    ibus_word = 32'h1234_5678;
    cyc(10);
    chk("R8 no reload on hold", load_cnt, 1);
    chk("R8 jam word held", jam_word, 32'hA5C3_0F1E);

    // R7 step from JAM
    step_cnt = 0;
    mode_req_a = 2'b10;
    cyc(10);
    chk("R7 one step", step_cnt, 1);
    chk("R7 back to HALT", mode_stat, 2'b01);
    // R11 repeat of same request does nothing
    mode_req_a = 2'b10;
    cyc(10);
    chk("R11 no second step", step_cnt, 1);
    last_req = 2'b10;
    cur = 2'b01;

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] t;
      logic [W-1:0] w;
      t = 2'($urandom_range(0, 3));
      w = $urandom;
      ibus_word = w;
      step_cnt = 0; load_cnt = 0;
      mode_req_a = t;
      cyc(10);
      if (t != last_req && cur == 2'b00 && t != 2'b00) begin
        chk("R6 random waits", mode_stat, 2'b00);
        insn_boundary = 1'b1; cyc(1); insn_boundary = 1'b0;
        cyc(2);
      end
      if (t != last_req) begin
        chk("R2 random mode", mode_stat, exp_after(t));
        chk("R7 random steps", step_cnt, (t == 2'b10) ? 1 : 0);
        chk("R8 random loads", load_cnt, (t == 2'b11) ? 1 : 0);
        if (t == 2'b11) chk("R8 random word", jam_word, w);
        cur = exp_after(t);
        last_req = t;
      end else begin
        chk("R11 random repeat mode", mode_stat, cur);
        chk("R11 random repeat loads", load_cnt, 0);
        if (cur != 2'b00) chk("R11 random repeat steps", step_cnt, 0);
      end
      chk("R5 random fetch", fetch_en, (cur == 2'b00) ? 1 : 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule